// File: doc/BRIEF.md
# Accumulator and Quotient Register Setup Unit

This block holds the working registers of an arithmetic unit: an 18-bit accumulator, an 18-bit multiplier-quotient register, a one-bit link and a 6-bit step counter. When `op_valid` is high, it carries out one register setup operation chosen by `op_sel`. The operations combine or move data between the registers, complement the quotient register, and produce absolute-value and sign/magnitude forms of the accumulator. Each operation finishes in one clock, whatever the data.

Preset ports write any register directly, and read-back ports show all four registers at all times. A surrounding sequencer, or a testbench, uses the presets to set up operands, issues operations and watches `done`. Bit numbering follows the register convention in which bit 0 is the most significant bit. Port bit `[17]` is register bit 0 (the sign), and port bits `[5:0]` are register bits 12 to 17.

Top module: `setup_unit`

## Requirements
- R1: After reset, AC, MQ, link and SC read zero and `done` is low.
- R2: A preset enable loads its value into its register at the clock edge. When a preset and an operation target the same register in the same cycle, the preset value wins.
- R3: Code 1 (OR step counter) ORs SC into AC bits 12..17 (`ac_out[5:0]`). AC bits 0..11 and SC stay unchanged.
- R4: Code 2 (OR quotient) sets AC to AC OR MQ. MQ stays unchanged.
- R5: Code 3 inverts every MQ bit. Code 7 clears MQ to zero.
- R6: Code 4 clears AC and places SC in `ac_out[5:0]`. Code 5 copies MQ into AC. Both leave their source unchanged.
- R7: Code 6 (absolute value) inverts all AC bits (one's complement) only when `ac_out[17]` is 1. Otherwise AC is kept.
- R8: Code 9 (sign and magnitude) copies `ac_out[17]` into the link and inverts AC if that bit was 1.
- R9: Code 8 copies AC into MQ. AC stays unchanged.
- R10: Every legal operation updates its registers at the clock edge that accepts it. `done` is high for exactly the one cycle after that edge.
- R11: Codes 0 and 10..15, and any cycle with `op_valid` low, change no register and raise no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_sel | input | 4 | Operation code |
| ac_ld_en | input | 1 | Preset accumulator |
| ac_ld_val | input | 18 | Accumulator preset value |
| mq_ld_en | input | 1 | Preset quotient register |
| mq_ld_val | input | 18 | Quotient register preset value |
| link_ld_en | input | 1 | Preset link |
| link_ld_val | input | 1 | Link preset value |
| sc_ld_en | input | 1 | Preset step counter |
| sc_ld_val | input | 6 | Step counter preset value |
| ac_out | output | 18 | Accumulator contents |
| mq_out | output | 18 | Quotient register contents |
| link_out | output | 1 | Link contents |
| sc_out | output | 6 | Step counter contents |
| done | output | 1 | One-cycle completion pulse |

## Verification
The conditional operations, absolute value and sign/magnitude, each have a branch that is hard to reach from the ports. Both branches are taken only if the accumulator's top bit and the link are preset to opposing values beforehand. Otherwise a test cannot tell a stale link from a freshly written one. The bench therefore presets the link to the inverse of the expected sign before each of these operations. It runs each one with the sign set and with the sign clear. It also issues an operation in the same cycle as a preset of the same register, which exercises the override path.

// File: rtl/setup_unit_pkg.sv
package setup_unit_pkg;
    localparam int DATA_W = 18;
    localparam int SC_W   = 6;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE     = 4'd0,
        OP_OR_SC    = 4'd1,
        OP_OR_MQ    = 4'd2,
        OP_CPL_MQ   = 4'd3,
        OP_AC_GETSC = 4'd4,
        OP_AC_GETMQ = 4'd5,
        OP_ABS      = 4'd6,
        OP_CLR_MQ   = 4'd7,
        OP_MQ_GETAC = 4'd8,
        OP_SIGN_MAG = 4'd9
    } setup_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] mq;
        logic              link;
        logic [SC_W-1:0]   sc;
    } regs_t;
endpackage

// File: rtl/setup_op_decode.sv
module setup_op_decode
    import setup_unit_pkg::*;
(
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_sel,
    output logic            accept,
    output setup_op_e       op
);
    logic legal;

    always_comb begin
        legal = (op_sel >= OP_W'(OP_OR_SC)) && (op_sel <= OP_W'(OP_SIGN_MAG));
        accept = op_valid && legal;
        op = accept ? setup_op_e'(op_sel) : OP_NONE;
    end
endmodule

// File: rtl/setup_datapath.sv
module setup_datapath
    import setup_unit_pkg::*;
(
    input  regs_t     cur,
    input  setup_op_e op,
    output regs_t     nxt
);
    localparam int PAD_W = DATA_W - SC_W;

    logic              sign;
    logic [DATA_W-1:0] sc_wide;
    logic [DATA_W-1:0] ac_mag;

    always_comb begin
        sign    = cur.ac[DATA_W-1];
        sc_wide = {{PAD_W{1'b0}}, cur.sc};
        ac_mag  = sign ? ~cur.ac : cur.ac;
        nxt     = cur;
        case (op)
            OP_OR_SC:    nxt.ac = cur.ac | sc_wide;
            OP_OR_MQ:    nxt.ac = cur.ac | cur.mq;
            OP_CPL_MQ:   nxt.mq = ~cur.mq;
            OP_AC_GETSC: nxt.ac = sc_wide;
            OP_AC_GETMQ: nxt.ac = cur.mq;
            OP_ABS:      nxt.ac = ac_mag;
            OP_CLR_MQ:   nxt.mq = '0;
            OP_MQ_GETAC: nxt.mq = cur.ac;
            OP_SIGN_MAG: begin
                nxt.link = sign;
                nxt.ac   = ac_mag;
            end
            default:     nxt = cur;
        endcase
    end
endmodule

// File: rtl/setup_unit.sv
module setup_unit
    import setup_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic              ac_ld_en,
    input  logic [DATA_W-1:0] ac_ld_val,
    input  logic              mq_ld_en,
    input  logic [DATA_W-1:0] mq_ld_val,
    input  logic              link_ld_en,
    input  logic              link_ld_val,
    input  logic              sc_ld_en,
    input  logic [SC_W-1:0]   sc_ld_val,
    output logic [DATA_W-1:0] ac_out,
    output logic [DATA_W-1:0] mq_out,
    output logic              link_out,
    output logic [SC_W-1:0]   sc_out,
    output logic              done
);
    localparam int LOW_W = SC_W;

    regs_t     regs_q, regs_d, op_res;
    logic      done_q, done_d;
    logic      accept;
    setup_op_e op;

    setup_op_decode u_dec (
        .op_valid (op_valid),
        .op_sel   (op_sel),
        .accept   (accept),
        .op       (op)
    );

    setup_datapath u_dp (
        .cur (regs_q),
        .op  (op),
        .nxt (op_res)
    );

    always_comb begin
        regs_d = op_res;
        if (ac_ld_en)   regs_d.ac   = ac_ld_val;
        if (mq_ld_en)   regs_d.mq   = mq_ld_val;
        if (link_ld_en) regs_d.link = link_ld_val;
        if (sc_ld_en)   regs_d.sc   = sc_ld_val;
        done_d = accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
            done_q <= 1'b0;
        end else begin
            regs_q <= regs_d;
            done_q <= done_d;
        end
    end

    assign ac_out   = regs_q.ac;
    assign mq_out   = regs_q.mq;
    assign link_out = regs_q.link;
    assign sc_out   = regs_q.sc;
    assign done     = done_q;

    logic no_ld;
    assign no_ld = !ac_ld_en && !mq_ld_en && !link_ld_en && !sc_ld_en;

    p_or_sc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd1 && no_ld) |=>
        (ac_out[LOW_W-1:0] == ($past(ac_out[LOW_W-1:0]) | $past(sc_out)))
        && $stable(ac_out[DATA_W-1:LOW_W]) && $stable(sc_out));

    p_or_mq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd2 && no_ld) |=>
        (ac_out == ($past(ac_out) | $past(mq_out))) && $stable(mq_out));

    p_clr_mq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd7 && no_ld) |=> (mq_out == '0));

    p_abs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd6 && no_ld) |=>
        !ac_out[DATA_W-1] && $stable(link_out));

    p_sign_mag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd9 && no_ld) |=>
        (link_out == $past(ac_out[DATA_W-1])) && !ac_out[DATA_W-1]);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done || $past(accept));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && no_ld) |=> $stable(ac_out) && $stable(mq_out)
        && $stable(link_out) && $stable(sc_out) && !done);
endmodule

// File: tb/setup_unit_bench.sv
module setup_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        ac_ld_en = 1'b0, mq_ld_en = 1'b0, link_ld_en = 1'b0, sc_ld_en = 1'b0;
    logic [17:0] ac_ld_val = '0, mq_ld_val = '0;
    logic        link_ld_val = 1'b0;
    logic [5:0]  sc_ld_val = '0;
    logic [17:0] ac_out, mq_out;
    logic        link_out, done;
    logic [5:0]  sc_out;
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    setup_unit u_setup_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .ac_ld_en(ac_ld_en), .ac_ld_val(ac_ld_val),
        .mq_ld_en(mq_ld_en), .mq_ld_val(mq_ld_val),
        .link_ld_en(link_ld_en), .link_ld_val(link_ld_val),
        .sc_ld_en(sc_ld_en), .sc_ld_val(sc_ld_val),
        .ac_out(ac_out), .mq_out(mq_out), .link_out(link_out),
        .sc_out(sc_out), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [17:0] ac, input logic [17:0] mq,
                             input logic lk, input logic [5:0] sc, input logic dn);
        chk({tag, " ac"}, 32'(ac_out), 32'(ac));
        chk({tag, " mq"}, 32'(mq_out), 32'(mq));
        chk({tag, " link"}, 32'(link_out), 32'(lk));
        chk({tag, " sc"}, 32'(sc_out), 32'(sc));
        chk({tag, " done"}, 32'(done), 32'(dn));
    endtask

    task automatic preset(input logic [17:0] ac, input logic [17:0] mq,
                          input logic lk, input logic [5:0] sc);
        @(negedge clk);
        ac_ld_en = 1; mq_ld_en = 1; link_ld_en = 1; sc_ld_en = 1;
        ac_ld_val = ac; mq_ld_val = mq; link_ld_val = lk; sc_ld_val = sc;
        @(negedge clk);
        ac_ld_en = 0; mq_ld_en = 0; link_ld_en = 0; sc_ld_en = 0;
    endtask

    task automatic issue(input logic [3:0] code, input logic vld);
        op_valid = vld; op_sel = code;
        @(negedge clk);
        op_valid = 0; op_sel = '0;
    endtask

    task automatic t_reset;
        check_all("R1 reset", '0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_presets;
        preset(18'h2A5A5, 18'h15A5A, 1'b1, 6'h2B);
        check_all("R2 preset", 18'h2A5A5, 18'h15A5A, 1'b1, 6'h2B, 1'b0);
    endtask

    task automatic t_or_sc;
        preset(18'h3F0C0, 18'h00001, 1'b0, 6'h15);
        issue(4'd1, 1);
        check_all("R3 or_sc", 18'h3F0D5, 18'h00001, 1'b0, 6'h15, 1'b1);
        @(negedge clk);
        chk("R10 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_or_mq;
        preset(18'h0F00F, 18'h30303, 1'b1, 6'h01);
        issue(4'd2, 1);
        check_all("R4 or_mq", 18'h3F30F, 18'h30303, 1'b1, 6'h01, 1'b1);
    endtask

    task automatic t_mq_ops;
        preset(18'h12345, 18'h0FF00, 1'b0, 6'h07);
        issue(4'd3, 1);
        check_all("R5 cpl_mq", 18'h12345, 18'h300FF, 1'b0, 6'h07, 1'b1);
        issue(4'd7, 1);
        check_all("R5 clr_mq", 18'h12345, 18'h00000, 1'b0, 6'h07, 1'b1);
    endtask

    task automatic t_ac_loads;
        preset(18'h3FFFF, 18'h2B00C, 1'b1, 6'h3A);
        issue(4'd4, 1);
        check_all("R6 ac_from_sc", 18'h0003A, 18'h2B00C, 1'b1, 6'h3A, 1'b1);
        issue(4'd5, 1);
        check_all("R6 ac_from_mq", 18'h2B00C, 18'h2B00C, 1'b1, 6'h3A, 1'b1);
    endtask

    task automatic t_abs;
        preset(18'h20001, 18'h00000, 1'b0, 6'h00);
        issue(4'd6, 1);
        check_all("R7 abs neg", 18'h1FFFE, 18'h00000, 1'b0, 6'h00, 1'b1);
        preset(18'h1ABCD, 18'h00000, 1'b1, 6'h00);
        issue(4'd6, 1);
        check_all("R7 abs pos", 18'h1ABCD, 18'h00000, 1'b1, 6'h00, 1'b1);
    endtask

    task automatic t_sign_mag;
        preset(18'h3FFF0, 18'h00055, 1'b0, 6'h11);
        issue(4'd9, 1);
        check_all("R8 sign_mag neg", 18'h0000F, 18'h00055, 1'b1, 6'h11, 1'b1);
        preset(18'h0F0F0, 18'h00055, 1'b1, 6'h11);
        issue(4'd9, 1);
        check_all("R8 sign_mag pos", 18'h0F0F0, 18'h00055, 1'b0, 6'h11, 1'b1);
    endtask

    task automatic t_mq_from_ac;
        preset(18'h24924, 18'h3FFFF, 1'b0, 6'h05);
        issue(4'd8, 1);
        check_all("R9 mq_from_ac", 18'h24924, 18'h24924, 1'b0, 6'h05, 1'b1);
    endtask

    task automatic t_unused;
        preset(18'h11111, 18'h22222, 1'b1, 6'h33);
        issue(4'd0, 1);
        check_all("R11 code0", 18'h11111, 18'h22222, 1'b1, 6'h33, 1'b0);
        for (int c = 10; c < 16; c++) begin
            issue(4'(c), 1);
            check_all("R11 unused code", 18'h11111, 18'h22222, 1'b1, 6'h33, 1'b0);
        end
        issue(4'd3, 0);
        check_all("R11 valid low", 18'h11111, 18'h22222, 1'b1, 6'h33, 1'b0);
    endtask

    task automatic t_override;
        preset(18'h00F00, 18'h00000, 1'b0, 6'h00);
        mq_ld_en = 1; mq_ld_val = 18'h2AAAA;
        issue(4'd7, 1);
        mq_ld_en = 0;
        check_all("R2 override", 18'h00F00, 18'h2AAAA, 1'b0, 6'h00, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_presets();
        t_or_sc();
        t_or_mq();
        t_mq_ops();
        t_ac_loads();
        t_abs();
        t_sign_mag();
        t_mq_from_ac();
        t_unused();
        t_override();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule